// File: doc/BRIEF.md
# GPIO Interrupt Trigger Detector

This block turns a bank of already-debounced pin levels into interrupt requests. For each pin, a small control set picks edge or level detection and the active polarity. When the configured condition is seen on an interrupt-enabled pin, a sticky status bit is set. Software clears that bit by writing a 1 into the matching clear strobe. A separate wake-status flag can be armed per pin. It is set by the same detection and takes no account of the interrupt gates.

The request from a pin is raised while either of two things holds. The first is that the interrupt status is set and the pin is both enabled and unmasked. The second is that the pin's wake status is set. Requests are OR-ed per group of pins into summary bits, and then into one overall interrupt line. Because enable and unmask are independent gates, an edge can be recorded while the pin is masked and delivered later when it is unmasked.

Top module: `irq_trigger_bank`

## Requirements
- R1: With the trigger-type bit at 0 (edge) and polarity code 01, a low-to-high change of the pin sets the interrupt status one clock after the pin change is sampled; a high-to-low change does not set it.
- R2: With edge detection and polarity code 00, only a high-to-low change sets the interrupt status.
- R3: With edge detection and polarity code 10, both rising and falling changes set the interrupt status.
- R4: Polarity code 11 never sets a status, in either detection type; with the trigger-type bit at 1 (level), code 10 also never sets a status.
- R5: With level detection, the status is set while the pin sits at the active level (high for code 01, low for code 00), and it stays set after the pin leaves that level.
- R6: A 1 on a pin's interrupt-clear strobe clears its interrupt status. In level mode the clear takes priority in that cycle, and the status sets again on the next cycle if the level is still active.
- R7: In edge mode, a qualifying edge that arrives in the same cycle as a clear strobe is kept: the status reads 1 afterwards.
- R8: With interrupt enable at 0, no event is recorded in the interrupt status.
- R9: With enable at 1 and unmask at 0, an event is recorded in the status but the pin request stays low; setting unmask to 1 raises the request without a new event.
- R10: With wake enable at 1, an event sets the wake status even when interrupt enable and unmask are 0. The wake status raises the pin request, and a 1 on the wake-clear strobe clears it.
- R11: Group summary bit g is the OR of the requests of pins g*GROUP_SIZE to g*GROUP_SIZE+GROUP_SIZE-1, and the overall interrupt is the OR of all requests.
- R12: During reset and right after it, all status bits read 0. A pin that is already at its active edge's final level when reset is released causes no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NUM_PINS | Debounced pin levels |
| cfg_level_mode | input | NUM_PINS | Per pin: 1 level detection, 0 edge detection |
| cfg_polarity | input | 2*NUM_PINS | Per pin, bits [2i+1:2i]: 00 low/falling, 01 high/rising, 10 both edges, 11 none |
| cfg_int_en | input | NUM_PINS | Per-pin interrupt enable (gates capture and request) |
| cfg_unmask | input | NUM_PINS | Per-pin unmask, 1 delivers the request |
| cfg_wake_en | input | NUM_PINS | Per-pin wake capture enable |
| int_clr | input | NUM_PINS | Write-1-to-clear strobes for interrupt status |
| wake_clr | input | NUM_PINS | Write-1-to-clear strobes for wake status |
| int_status | output | NUM_PINS | Sticky interrupt status |
| wake_status | output | NUM_PINS | Sticky wake status |
| pin_req | output | NUM_PINS | Per-pin request into the summary tree |
| grp_pending | output | NUM_GROUPS | Per-group OR of pin requests |
| irq_out | output | 1 | OR of all pin requests |

## Verification
The assertions check several properties on every cycle, pin by pin. A disabled pin never gains interrupt or wake status, and code 11 never sets a status. A set status holds until cleared, and a clear in level mode always leaves the status at 0. A masked pin without wake status never raises a request. The other behaviours need a history of pin values and can only be shown by the bench's scenarios: which edge each polarity code selects, the re-assertion after a clear in level mode, an edge surviving a simultaneous clear, delayed delivery on unmask, group summaries, and the absence of a spurious edge at reset release.

// File: rtl/irq_trig_pkg.sv
// Shared encodings for the interrupt trigger detector.
package irq_trig_pkg;
    // Polarity code per pin; the numeric values are decoded by the detector.
    typedef enum logic [1:0] {
        POL_LOW  = 2'b00,
        POL_HIGH = 2'b01,
        POL_BOTH = 2'b10,
        POL_NONE = 2'b11
    } pol_e;
endpackage

// File: rtl/irq_event_detect.sv
// Per-pin event detector.
// Compares the pin with its previous sample and applies the polarity and
// trigger-type selection. Assumes pin is already synchronous and debounced.
// The history register also tracks the pin during reset, so the first cycle
// after reset sees no false edge.
module irq_event_detect
    import irq_trig_pkg::*;
(
    input  logic       clk,
    input  logic       pin,
    input  logic       level_mode,
    input  logic [1:0] polarity,
    output logic       hit
);
    logic prev_q;
    logic rise;
    logic fall;

    // Keep the last sampled pin level (tracked in reset too).
    always_ff @(posedge clk) begin
        prev_q <= pin;
    end

    assign rise = pin & ~prev_q;
    assign fall = ~pin & prev_q;

    // Select the qualifying condition from trigger type and polarity.
    always_comb begin
        hit = 1'b0;
        if (level_mode) begin
            unique case (pol_e'(polarity))
                POL_LOW:  hit = ~pin;
                POL_HIGH: hit = pin;
                default:  hit = 1'b0;
            endcase
        end else begin
            unique case (pol_e'(polarity))
                POL_LOW:  hit = fall;
                POL_HIGH: hit = rise;
                POL_BOTH: hit = rise | fall;
                default:  hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irq_status_latch.sv
// Per-pin sticky status pair (interrupt and wake).
// Set by a qualified hit; cleared by write-1 strobes. In level mode a clear
// wins in its cycle (the level re-sets it next cycle). In edge mode a hit in
// the clear cycle is kept so that no edge is lost.
module irq_status_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic level_mode,
    input  logic int_en,
    input  logic wake_en,
    input  logic int_clr,
    input  logic wake_clr,
    output logic int_sts,
    output logic wake_sts
);
    logic int_set;
    logic wake_set;

    assign int_set  = hit & int_en;
    assign wake_set = hit & wake_en;

    // Interrupt status: sticky set, write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_sts <= 1'b0;
        end else if (int_clr) begin
            int_sts <= int_set & ~level_mode;
        end else if (int_set) begin
            int_sts <= 1'b1;
        end
    end

    // Wake status: same rules, independent of the interrupt gates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_sts <= 1'b0;
        end else if (wake_clr) begin
            wake_sts <= wake_set & ~level_mode;
        end else if (wake_set) begin
            wake_sts <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_summary_tree.sv
// OR summary of pin requests: one bit per group of GROUP_SIZE pins and one
// overall line. A last partial group is padded with zeros.
module irq_summary_tree #(
    parameter int NUM_PINS   = 8,
    parameter int GROUP_SIZE = 4,
    localparam int NUM_GROUPS = (NUM_PINS + GROUP_SIZE - 1) / GROUP_SIZE,
    localparam int PADDED     = NUM_GROUPS * GROUP_SIZE
) (
    input  logic [NUM_PINS-1:0]   req,
    output logic [NUM_GROUPS-1:0] grp,
    output logic                  any
);
    logic [PADDED-1:0] req_pad;

    // Zero-extend the request vector to whole groups.
    always_comb begin
        req_pad = '0;
        req_pad[NUM_PINS-1:0] = req;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp[g] = |req_pad[g*GROUP_SIZE +: GROUP_SIZE];
    end

    assign any = |grp;
endmodule

// File: rtl/irq_trigger_bank.sv
// Bank of per-pin interrupt trigger detectors with a grouped summary.
// Each pin has an event detector and a sticky status pair. A request is
// raised for gated interrupt status or for wake status.
// Assumes pin_level is synchronous to clk and already filtered.
module irq_trigger_bank #(
    parameter int NUM_PINS   = 8,
    parameter int GROUP_SIZE = 4,
    localparam int NUM_GROUPS = (NUM_PINS + GROUP_SIZE - 1) / GROUP_SIZE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_level,
    input  logic [NUM_PINS-1:0]   cfg_level_mode,
    input  logic [2*NUM_PINS-1:0] cfg_polarity,
    input  logic [NUM_PINS-1:0]   cfg_int_en,
    input  logic [NUM_PINS-1:0]   cfg_unmask,
    input  logic [NUM_PINS-1:0]   cfg_wake_en,
    input  logic [NUM_PINS-1:0]   int_clr,
    input  logic [NUM_PINS-1:0]   wake_clr,
    output logic [NUM_PINS-1:0]   int_status,
    output logic [NUM_PINS-1:0]   wake_status,
    output logic [NUM_PINS-1:0]   pin_req,
    output logic [NUM_GROUPS-1:0] grp_pending,
    output logic                  irq_out
);
    logic [NUM_PINS-1:0] hit;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        irq_event_detect u_det (
            .clk        (clk),
            .pin        (pin_level[i]),
            .level_mode (cfg_level_mode[i]),
            .polarity   (cfg_polarity[2*i +: 2]),
            .hit        (hit[i])
        );

        irq_status_latch u_sts (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit[i]),
            .level_mode (cfg_level_mode[i]),
            .int_en     (cfg_int_en[i]),
            .wake_en    (cfg_wake_en[i]),
            .int_clr    (int_clr[i]),
            .wake_clr   (wake_clr[i]),
            .int_sts    (int_status[i]),
            .wake_sts   (wake_status[i])
        );

        // Request: status passes both gates, or wake is pending.
        assign pin_req[i] = (int_status[i] & cfg_int_en[i] & cfg_unmask[i])
                          | wake_status[i];
    end

    irq_summary_tree #(
        .NUM_PINS   (NUM_PINS),
        .GROUP_SIZE (GROUP_SIZE)
    ) u_sum (
        .req (pin_req),
        .grp (grp_pending),
        .any (irq_out)
    );
endmodule

// File: rtl/irq_trigger_bank_chk.sv
// Checker for irq_trigger_bank: per-pin cycle properties, bound to the top.
module irq_trigger_bank_chk #(
    parameter int NUM_PINS   = 8,
    parameter int GROUP_SIZE = 4,
    localparam int NUM_GROUPS = (NUM_PINS + GROUP_SIZE - 1) / GROUP_SIZE
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pin_level,
    input logic [NUM_PINS-1:0]   cfg_level_mode,
    input logic [2*NUM_PINS-1:0] cfg_polarity,
    input logic [NUM_PINS-1:0]   cfg_int_en,
    input logic [NUM_PINS-1:0]   cfg_unmask,
    input logic [NUM_PINS-1:0]   cfg_wake_en,
    input logic [NUM_PINS-1:0]   int_clr,
    input logic [NUM_PINS-1:0]   wake_clr,
    input logic [NUM_PINS-1:0]   int_status,
    input logic [NUM_PINS-1:0]   wake_status,
    input logic [NUM_PINS-1:0]   pin_req,
    input logic [NUM_GROUPS-1:0] grp_pending,
    input logic                  irq_out
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R4: undefined polarity code never sets a clear status.
        a_r4_code11_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (!int_status[i] && cfg_polarity[2*i +: 2] == 2'b11) |=> !int_status[i]);

        // R8: a disabled pin records nothing.
        a_r8_disabled_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (!int_status[i] && !cfg_int_en[i]) |=> !int_status[i]);

        // R5: status is sticky until a clear strobe.
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (int_status[i] && !int_clr[i]) |=> int_status[i]);

        // R6: in level mode a clear always wins its cycle.
        a_r6_level_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (int_clr[i] && cfg_level_mode[i]) |=> !int_status[i]);

        // R9: a masked pin without wake status raises no request.
        a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_unmask[i] && !wake_status[i]) |-> !pin_req[i]);

        // R10: wake status cannot appear while wake capture is off.
        a_r10_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
            (!wake_status[i] && !cfg_wake_en[i]) |=> !wake_status[i]);
    end
endmodule

bind irq_trigger_bank irq_trigger_bank_chk #(
    .NUM_PINS   (NUM_PINS),
    .GROUP_SIZE (GROUP_SIZE)
) u_chk (.*);

// File: tb/tb_irq_trigger_bank.sv
`timescale 1ns/1ps
module tb_irq_trigger_bank;
    localparam int NP = 8;
    localparam int GS = 4;
    localparam int NG = 2;
    localparam int NV = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pin_level, cfg_level_mode, cfg_int_en, cfg_unmask, cfg_wake_en;
    logic [NP-1:0] int_clr, wake_clr;
    logic [2*NP-1:0] cfg_polarity;
    logic [NP-1:0] int_status, wake_status, pin_req;
    logic [NG-1:0] grp_pending;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_trigger_bank #(.NUM_PINS(NP), .GROUP_SIZE(GS)) dut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
        .cfg_level_mode(cfg_level_mode), .cfg_polarity(cfg_polarity),
        .cfg_int_en(cfg_int_en), .cfg_unmask(cfg_unmask), .cfg_wake_en(cfg_wake_en),
        .int_clr(int_clr), .wake_clr(wake_clr), .int_status(int_status),
        .wake_status(wake_status), .pin_req(pin_req), .grp_pending(grp_pending),
        .irq_out(irq_out)
    );

    // Vector: {req_id[3:0], level, pol[1:0], en, unmask, pin, clr, exp_sts, exp_req}
    localparam logic [12:0] VEC [NV] = '{
        13'b0001_0_01_1_1_0_0_0_0, // R1 idle low
        13'b0001_0_01_1_1_1_0_1_1, // R1 rise sets
        13'b0110_0_01_1_1_1_1_0_0, // R6 clear
        13'b0001_0_01_1_1_0_0_0_0, // R1 fall ignored
        13'b0010_0_00_1_1_0_0_0_0, // R2 steady low
        13'b0010_0_00_1_1_1_0_0_0, // R2 rise ignored
        13'b0010_0_00_1_1_0_0_1_1, // R2 fall sets
        13'b0110_0_00_1_1_0_1_0_0, // R6 clear
        13'b0011_0_10_1_1_1_0_1_1, // R3 rise
        13'b0110_0_10_1_1_1_1_0_0, // R6 clear
        13'b0011_0_10_1_1_0_0_1_1, // R3 fall
        13'b0110_0_10_1_1_0_1_0_0, // R6 clear
        13'b0100_0_11_1_1_1_0_0_0, // R4 code 11 rise
        13'b0100_0_11_1_1_0_0_0_0, // R4 code 11 fall
        13'b0101_1_01_1_1_1_0_1_1, // R5 level high
        13'b0110_1_01_1_1_1_1_0_0, // R6 clear wins
        13'b0110_1_01_1_1_1_0_1_1, // R6 re-asserts
        13'b0101_1_01_1_1_0_0_1_1, // R5 sticky
        13'b0110_1_01_1_1_0_1_0_0, // R6 clear
        13'b0101_1_00_1_1_0_0_1_1, // R5 level low
        13'b0110_1_00_1_1_0_1_0_0, // R6 clear wins
        13'b0100_1_10_1_1_0_0_0_0, // R4 level code 10 low
        13'b0100_1_10_1_1_1_0_0_0, // R4 level code 10 high
        13'b0100_1_11_1_1_1_0_0_0, // R4 level code 11
        13'b1000_0_01_0_1_0_0_0_0, // R8 disabled
        13'b1000_0_01_0_1_1_0_0_0, // R8 rise while disabled
        13'b1001_0_01_1_0_0_0_0_0, // R9 masked idle
        13'b1001_0_01_1_0_1_0_1_0, // R9 captured, no request
        13'b1001_0_01_1_1_1_0_1_1, // R9 unmask delivers
        13'b0110_0_01_1_1_0_1_0_0, // R6 clear
        13'b0111_0_01_1_1_1_1_1_1, // R7 edge beats clear
        13'b0110_0_01_1_1_1_1_0_0  // R6 clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        pin_level = '0; cfg_level_mode = '0; cfg_polarity = '0;
        cfg_int_en = '0; cfg_unmask = '0; cfg_wake_en = '0;
        int_clr = '0; wake_clr = '0;
        // Pin 1: rising-edge, enabled, held high through reset (R12).
        cfg_polarity[3:2] = 2'b01; cfg_int_en[1] = 1'b1; cfg_unmask[1] = 1'b1;
        pin_level[1] = 1'b1;
        @(negedge clk);
        step(); step();
        check("R12 status in reset", {wake_status, int_status}, 32'h0);
        check("R12 irq in reset", irq_out, 1'b0);
        rst_n = 1'b1;
        step(); step();
        check("R12 no edge at release", int_status[1], 1'b0);
        check("R12 no request at release", pin_req, 8'h00);

        // Table walk on pin 0.
        for (int v = 0; v < NV; v++) begin
            logic [12:0] e;
            e = VEC[v];
            cfg_level_mode[0] = e[8];
            cfg_polarity[1:0] = e[7:6];
            cfg_int_en[0]     = e[5];
            cfg_unmask[0]     = e[4];
            pin_level[0]      = e[3];
            int_clr[0]        = e[2];
            step();
            check($sformatf("R%0d vec%0d status", e[12:9], v), int_status[0], e[1]);
            check($sformatf("R%0d vec%0d request", e[12:9], v), pin_req[0], e[0]);
            check($sformatf("R11 vec%0d irq_out", v), irq_out, e[0]);
        end
        int_clr = '0;
        cfg_int_en[0] = 1'b0;
        step();

        // R10: wake on pin 5 with interrupt gates closed.
        cfg_polarity[11:10] = 2'b01; cfg_wake_en[5] = 1'b1;
        pin_level[5] = 1'b1;
        step();
        check("R10 wake set", wake_status[5], 1'b1);
        check("R10 int untouched", int_status[5], 1'b0);
        check("R10 wake request", pin_req[5], 1'b1);
        check("R11 group1 only", grp_pending, 2'b10);
        check("R11 irq_out wake", irq_out, 1'b1);
        wake_clr[5] = 1'b1;
        step();
        wake_clr[5] = 1'b0;
        check("R10 wake cleared", wake_status[5], 1'b0);
        check("R11 irq idle", irq_out, 1'b0);

        // R11: pin 2 (group 0) and pin 6 (group 1) independent.
        cfg_polarity[5:4] = 2'b00; cfg_int_en[2] = 1'b1; cfg_unmask[2] = 1'b1;
        pin_level[2] = 1'b1;
        step();
        pin_level[2] = 1'b0;
        step();
        check("R2 pin2 fall", int_status[2], 1'b1);
        check("R11 group0 only", grp_pending, 2'b01);
        cfg_polarity[13:12] = 2'b10; cfg_int_en[6] = 1'b1; cfg_unmask[6] = 1'b1;
        pin_level[6] = 1'b1;
        step();
        check("R11 both groups", grp_pending, 2'b11);
        int_clr[2] = 1'b1;
        step();
        int_clr[2] = 1'b0;
        check("R11 group0 cleared", grp_pending, 2'b10);
        check("R6 pin6 untouched by pin2 clear", int_status[6], 1'b1);

        finish_run();
    end
endmodule